// File: doc/BRIEF.md
# Run-time Configurable SPI Master

This block is the master side of a four-wire serial peripheral link. It drives the serial clock, the active-low select and the outgoing data line, and samples the incoming data line. Each transfer moves one word of `W` bits in both directions at once. The host starts a transfer with a one-cycle `start` strobe and a parallel transmit word. When the word is complete, the block returns the received word and raises `done` for one cycle.

The host sets the operating mode at run time with a one-cycle `cfg_wr` strobe. The mode covers serial clock idle level, capture phase, bit order, an enable, and a divider value that fixes the serial clock rate. A single internal shift register handles both directions. The outgoing bit leaves from one end while the captured bit enters at the other. After `W` shifts the register holds the received word. The host may issue the next `start` in the very cycle that `done` is high, which chains words back to back.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, `ss_n`=1, `sclk`=0, `done`=0 and `rx_data`=0; the mode is disabled with clock idle level 0, phase 0, MSB first and divider 0.
- R2: While `ss_n` is low, `sclk` toggles every `cfg_baud_div`+1 clocks, starting at the idle level given by the clock polarity field. It makes exactly 2·W edges per word. `ss_n` stays low for (2·W+1)·(div+1) clock cycles. While `ss_n` stays high, `sclk` changes only after a configuration write.
- R3: A start accepted at a clock edge drives `ss_n` low from that edge on. The select goes low before the first `sclk` edge. `ss_n` rises again in the same cycle that `done` is high for exactly one clock.
- R4: `mosi` changes only when `sclk` changes, while `ss_n` stays low. With phase 0, the first bit is valid from the moment `ss_n` falls, `miso` is captured on leading edges, and `mosi` advances on trailing edges. With phase 1, `mosi` advances on leading edges after the first one, and `miso` is captured on trailing edges.
- R5: With LSB-first selected, bit 0 of `tx_data` is sent first, and the first captured bit lands in bit 0 of `rx_data`. Otherwise bit W-1 goes first and the first captured bit lands in bit W-1.
- R6: At `done`, `rx_data` holds the W bits captured from `miso` during that same word.
- R7: `rx_data` changes only in a cycle where `done` is high, and holds its value until the next `done`.
- R8: A `start` is ignored while a word is in progress and while the enable field is 0. `ss_n` falls only in the cycle after an accepted `start`.
- R9: A configuration write while a word is in progress, with `cfg_enable`=1, is ignored entirely. When `cfg_wr` and `start` are both high in an idle cycle, the write is applied and that start is dropped.
- R10: A configuration write with `cfg_enable`=0 during a word aborts it. On the next cycle `ss_n`=1, `sclk` is at the old idle level and no `done` appears. The enable becomes 0 and the write's other fields are not applied. The next accepted word starts again from its first bit.
- R11: A `start` given in the cycle where `done` is high is accepted. `ss_n` is then high for exactly that one cycle between the two words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe that writes the mode fields below |
| cfg_enable | input | 1 | Enable field; 0 disables and aborts |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit travels first |
| cfg_baud_div | input | DIV_W | Half-period of `sclk` minus one, in system clocks |
| start | input | 1 | One-cycle request to send `tx_data` |
| tx_data | input | W | Word to transmit, taken when a start is accepted |
| rx_data | output | W | Last received word |
| done | output | 1 | One-cycle pulse at the end of each word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
Two pairs of events can meet in one cycle. The first pair is the end of a word, where `done` rises, and a new `start`. The bench raises `start` in the very cycle it sees `done` high. It then expects `ss_n` to be high for that single cycle and low on the next one, with the second word's clocks and data matching a behavioural model. The second pair is a configuration write and a start in the same idle cycle. The bench drives both strobes together and judges that the select never falls, while the written mode is visible on the idle clock level.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    // Run-time mode fields of the serial master.
    typedef struct packed {
        logic en;    // enable
        logic cpol;  // clock idle level
        logic cpha;  // capture phase
        logic lsbf;  // least significant bit first
    } spi_cfg_t;

endpackage

// File: rtl/spi_baud_tick.sv
// Half-period timer: pulses tick once every (div + 1) clocks while run is high.
module spi_baud_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = run && (cnt_q == div);
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_word_shifter.sv
// One register serves both directions: the outgoing bit leaves one end,
// the captured bit enters the other end.
module spi_word_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         lsb_first,
    input  logic         shin,
    output logic [W-1:0] word,
    output logic         ser_out
);

    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load) begin
            word_d = load_val;
        end else if (shift) begin
            if (lsb_first) begin
                word_d = {shin, word_q[W-1:1]};
            end else begin
                word_d = {word_q[W-2:0], shin};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word    = word_q;
    assign ser_out = lsb_first ? word_q[0] : word_q[W-1];

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int W     = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_enable,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic [DIV_W-1:0] cfg_baud_div,
    input  logic             start,
    input  logic [W-1:0]     tx_data,
    output logic [W-1:0]     rx_data,
    output logic             done,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             ss_n
);

    localparam int                EDGE_W    = $clog2(2 * W + 1);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * W);
    localparam logic [EDGE_W-1:0] ONE_EDGE  = EDGE_W'(1);

    typedef struct packed {
        logic              active;
        spi_cfg_t          cfg;
        logic [DIV_W-1:0]  div;
        logic [EDGE_W-1:0] edge_n;
        logic              ph;
        logic              samp;
        logic              done;
        logic [W-1:0]      rx;
    } st_t;

    st_t s_d, s_q;

    logic              tick;
    logic              sh_load;
    logic              sh_shift;
    logic              sh_in;
    logic              ser_bit;
    logic [W-1:0]      sh_word;
    logic [EDGE_W-1:0] k;
    logic              lead;

    spi_baud_tick #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (s_q.active),
        .div  (s_q.div),
        .tick (tick)
    );

    spi_word_shifter #(.W(W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (tx_data),
        .shift    (sh_shift),
        .lsb_first(s_q.cfg.lsbf),
        .shin     (sh_in),
        .word     (sh_word),
        .ser_out  (ser_bit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_in    = s_q.samp;
        k        = s_q.edge_n + ONE_EDGE;
        lead     = k[0];

        if (!s_q.active) begin
            if (cfg_wr) begin
                s_d.cfg.en   = cfg_enable;
                s_d.cfg.cpol = cfg_cpol;
                s_d.cfg.cpha = cfg_cpha;
                s_d.cfg.lsbf = cfg_lsb_first;
                s_d.div      = cfg_baud_div;
            end else if (start && s_q.cfg.en) begin
                s_d.active = 1'b1;
                s_d.edge_n = '0;
                s_d.ph     = 1'b0;
                sh_load    = 1'b1;
            end
        end else if (cfg_wr && !cfg_enable) begin
            // abort: only the enable field of this write is applied
            s_d.active = 1'b0;
            s_d.cfg.en = 1'b0;
            s_d.edge_n = '0;
            s_d.ph     = 1'b0;
        end else if (tick) begin
            if (s_q.edge_n == LAST_EDGE) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
                s_d.rx     = sh_word;
                s_d.ph     = 1'b0;
            end else begin
                s_d.edge_n = k;
                s_d.ph     = ~s_q.ph;
                if (!s_q.cfg.cpha) begin
                    if (lead) begin
                        s_d.samp = miso;
                    end else begin
                        sh_shift = 1'b1;
                    end
                end else if (lead) begin
                    sh_shift = (k != ONE_EDGE);
                end else if (k == LAST_EDGE) begin
                    sh_shift = 1'b1;
                    sh_in    = miso;
                end else begin
                    s_d.samp = miso;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ss_n    = ~s_q.active;
    assign sclk    = s_q.cfg.cpol ^ s_q.ph;
    assign mosi    = ser_bit;
    assign done    = s_q.done;
    assign rx_data = s_q.rx;

endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_wr,
    input logic         cfg_enable,
    input logic         start,
    input logic         done,
    input logic         sclk,
    input logic         mosi,
    input logic         ss_n,
    input logic [W-1:0] rx_data
);

    // R2: idle clock level moves only through a configuration write
    p_sclk_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n && $past(ss_n) && !$past(cfg_wr)) |-> $stable(sclk));

    // R3: done lasts one cycle
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: select is released when done is shown
    p_done_ss_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ss_n);

    // R4: data out moves only together with a clock edge inside a word
    p_mosi_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && !$past(ss_n) && (mosi != $past(mosi))) |-> (sclk != $past(sclk)));

    // R7: received word changes only with done
    p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data != $past(rx_data)) |-> done);

    // R8: select falls only after a start request
    p_ss_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> $past(start));

    // R10: clearing enable mid-word releases select without done
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr && !cfg_enable && !ss_n) |-> (ss_n && !done));

endmodule

bind spi_xfer_master spi_xfer_master_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_enable(cfg_enable),
    .start     (start),
    .done      (done),
    .sclk      (sclk),
    .mosi      (mosi),
    .ss_n      (ss_n),
    .rx_data   (rx_data)
);

// File: tb/spi_xfer_master_test.sv
module spi_xfer_master_test;

    localparam int CLK_PERIOD = 10;
    localparam int WORD       = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_enable = 1'b0;
    logic             cfg_cpol = 1'b0;
    logic             cfg_cpha = 1'b0;
    logic             cfg_lsb_first = 1'b0;
    logic [7:0]       cfg_baud_div = '0;
    logic             start = 1'b0;
    logic [WORD-1:0]  tx_data = '0;
    logic [WORD-1:0]  rx_data;
    logic             done;
    logic             sclk;
    logic             mosi;
    logic             miso = 1'b0;
    logic             ss_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    spi_xfer_master #(.W(WORD), .DIV_W(8)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_enable   (cfg_enable),
        .cfg_cpol     (cfg_cpol),
        .cfg_cpha     (cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first),
        .cfg_baud_div (cfg_baud_div),
        .start        (start),
        .tx_data      (tx_data),
        .rx_data      (rx_data),
        .done         (done),
        .sclk         (sclk),
        .mosi         (mosi),
        .miso         (miso),
        .ss_n         (ss_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit        m_active, m_en, m_cpol, m_cpha, m_lsb, m_ph, m_samp, m_done, m_lead;
    int        m_div, m_cnt, m_edge;
    logic [WORD-1:0] m_rx;
    bit        txq[$];
    bit        rxq[$];

    function automatic logic [WORD-1:0] pack_rx();
        logic [WORD-1:0] w = '0;
        for (int b = 0; b < WORD; b++) begin
            if (m_lsb) w[b] = rxq[b];
            else       w[WORD-1-b] = rxq[b];
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_en = 0; m_cpol = 0; m_cpha = 0; m_lsb = 0;
            m_div = 0; m_cnt = 0; m_edge = 0; m_ph = 0; m_samp = 0;
            m_done = 0; m_rx = '0;
            txq.delete(); rxq.delete();
        end else begin
            m_done = 0;
            if (!m_active) begin
                if (cfg_wr) begin
                    m_en = cfg_enable; m_cpol = cfg_cpol; m_cpha = cfg_cpha;
                    m_lsb = cfg_lsb_first; m_div = int'(cfg_baud_div);
                end else if (start && m_en) begin
                    m_active = 1; m_cnt = 0; m_edge = 0; m_ph = 0;
                    txq.delete(); rxq.delete();
                    for (int b = 0; b < WORD; b++)
                        txq.push_back(m_lsb ? tx_data[b] : tx_data[WORD-1-b]);
                end
            end else if (cfg_wr && !cfg_enable) begin
                m_active = 0; m_en = 0; m_ph = 0;
            end else if (m_cnt == m_div) begin
                m_cnt = 0;
                if (m_edge == 2 * WORD) begin
                    m_active = 0; m_done = 1; m_rx = pack_rx();
                end else begin
                    m_edge++;
                    m_ph = !m_ph;
                    m_lead = (m_edge % 2) == 1;
                    if (!m_cpha) begin
                        if (m_lead) m_samp = miso;
                        else begin rxq.push_back(m_samp); void'(txq.pop_front()); end
                    end else if (m_lead) begin
                        if (m_edge > 1) begin rxq.push_back(m_samp); void'(txq.pop_front()); end
                    end else if (m_edge == 2 * WORD) begin
                        rxq.push_back(miso); void'(txq.pop_front());
                    end else begin
                        m_samp = miso;
                    end
                end
            end else begin
                m_cnt++;
            end
        end
    end

    // ---------------- per-cycle comparison and monitors ----------------
    int   edge_cnt = 0;
    int   low_cnt = 0;
    int   done_cnt = 0;
    logic prev_sclk = 1'b0;

    always @(negedge clk) begin
        miso <= 1'($urandom_range(0, 1));
        if (rst_n && !finished) begin
            check("R2 sclk", 32'(sclk), 32'(m_cpol ^ m_ph));
            check("R3 ss_n", 32'(ss_n), 32'(!m_active));
            check("R3 done", 32'(done), 32'(m_done));
            check("R7 rx_data", 32'(rx_data), 32'(m_rx));
            if (m_active && txq.size() > 0)
                check("R4 mosi", 32'(mosi), 32'(txq[0]));
            if (!ss_n && sclk != prev_sclk) edge_cnt++;
            if (!ss_n) low_cnt++;
            if (done) done_cnt++;
        end
        prev_sclk = sclk;
    end

    // ---------------- stimulus helpers ----------------
    task automatic write_cfg(input bit en, input bit cpol, input bit cpha, input bit lsb, input int div);
        @(negedge clk);
        cfg_wr = 1; cfg_enable = en; cfg_cpol = cpol; cfg_cpha = cpha;
        cfg_lsb_first = lsb; cfg_baud_div = 8'(div);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic kick(input logic [WORD-1:0] val);
        @(negedge clk);
        edge_cnt = 0; low_cnt = 0;
        start = 1; tx_data = val;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check("R3 done seen", 32'(done), 32'd1);
    endtask

    task automatic run_word(input string req, input bit cpol, input bit cpha, input bit lsb,
                            input int div, input logic [WORD-1:0] val);
        write_cfg(1, cpol, cpha, lsb, div);
        kick(val);
        wait_done();
        check({req, " rx word"}, 32'(rx_data), 32'(pack_rx()));
        check("R2 edge count", 32'(edge_cnt), 32'(2 * WORD));
        check("R2 select low cycles", 32'(low_cnt), 32'((2 * WORD + 1) * (div + 1)));
        @(negedge clk);
        check("R2 idle level", 32'(sclk), 32'(cpol));
    endtask

    // ---------------- test sequence ----------------
    initial begin
        int d0;
        logic [WORD-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 ss_n", 32'(ss_n), 32'd1);
        check("R1 sclk", 32'(sclk), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 rx_data", 32'(rx_data), 32'd0);

        // R6 / R5 across modes and rates
        run_word("R6 mode0 msb", 0, 0, 0, 0, 8'hA5);
        run_word("R6 mode3 msb", 1, 1, 0, 2, 8'h3C);
        run_word("R5 mode1 lsb", 0, 1, 1, 1, 8'h81);
        run_word("R5 mode2 lsb", 1, 0, 1, 3, 8'h6E);

        // R7: held word survives idle and part of the next word
        held = rx_data;
        repeat (10) @(negedge clk);
        check("R7 held idle", 32'(rx_data), 32'(held));
        write_cfg(1, 0, 0, 0, 1);
        kick(8'h12);
        repeat (9) @(negedge clk);
        check("R7 held mid-word", 32'(rx_data), 32'(held));
        wait_done();

        // R8: start while disabled
        write_cfg(0, 0, 0, 0, 0);
        d0 = done_cnt;
        kick(8'hFF);
        repeat (20) @(negedge clk);
        check("R8 disabled start ss_n", 32'(ss_n), 32'd1);
        check("R8 disabled start done", 32'(done_cnt - d0), 32'd0);

        // R8: start during a word
        write_cfg(1, 0, 1, 0, 0);
        d0 = done_cnt;
        kick(8'h5A);
        repeat (5) @(negedge clk);
        start = 1; tx_data = 8'h00;
        @(negedge clk);
        start = 0;
        wait_done();
        check("R8 busy start edges", 32'(edge_cnt), 32'(2 * WORD));
        repeat (25) @(negedge clk);
        check("R8 busy start one done", 32'(done_cnt - d0), 32'd1);

        // R9: write during a word with enable 1 is ignored
        write_cfg(1, 0, 0, 0, 1);
        kick(8'hC3);
        repeat (10) @(negedge clk);
        write_cfg(1, 1, 1, 1, 0);
        wait_done();
        check("R9 ignored write edges", 32'(edge_cnt), 32'(2 * WORD));
        @(negedge clk);
        check("R9 ignored write idle level", 32'(sclk), 32'd0);

        // R9: write and start in the same idle cycle
        @(negedge clk);
        cfg_wr = 1; cfg_enable = 1; cfg_cpol = 1; cfg_cpha = 0;
        cfg_lsb_first = 0; cfg_baud_div = 8'd0;
        start = 1; tx_data = 8'h99;
        @(negedge clk);
        cfg_wr = 0; start = 0;
        repeat (5) @(negedge clk);
        check("R9 same-cycle start dropped", 32'(ss_n), 32'd1);
        check("R9 same-cycle write applied", 32'(sclk), 32'd1);

        // R10: abort by clearing enable
        write_cfg(1, 0, 0, 0, 1);
        kick(8'hE7);
        repeat (12) @(negedge clk);
        d0 = done_cnt;
        write_cfg(0, 1, 1, 1, 4);
        check("R10 abort ss_n", 32'(ss_n), 32'd1);
        check("R10 abort sclk", 32'(sclk), 32'd0);
        repeat (30) @(negedge clk);
        check("R10 abort no done", 32'(done_cnt - d0), 32'd0);
        run_word("R10 restart", 0, 0, 0, 1, 8'h4B);

        // R11: back-to-back words
        write_cfg(1, 1, 1, 0, 0);
        kick(8'hD2);
        wait_done();
        check("R11 gap ss_n high", 32'(ss_n), 32'd1);
        start = 1; tx_data = 8'h2D;
        @(negedge clk);
        start = 0;
        edge_cnt = 0;
        check("R11 second word started", 32'(ss_n), 32'd0);
        wait_done();
        check("R11 second rx", 32'(rx_data), 32'(pack_rx()));
        check("R11 second edges", 32'(edge_cnt), 32'(2 * WORD));

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule